// File: doc/BRIEF.md
# Host Command Queue with Read Bypass

This block stores host read and write commands that have already been accepted upstream and are waiting for the sector-translation firmware to take them. Each stored entry holds a command type, a starting sector address and a sector count. An upstream tagged queue accepts up to 32 outstanding commands in FIFO order and feeds this block. This block holds up to 128 commands by default, set by a parameter.

Commands normally leave in arrival order. A read may leave ahead of older writes, which keeps the flash side busy while read data streams to the host. A read never leaves ahead of an older queued write whose sector range overlaps its own, so stale data is never returned. The consumer sees the selected entry on a show-ahead pop port and removes one entry per pop request. Every accepted push raises a one-cycle arrival interrupt. Full, empty and occupancy outputs and a sticky overflow error complete the interface.

Top module: `hostq_rdbypass`

## Requirements
- R1: `level` equals the number of stored entries (0 to DEPTH); `full` is high exactly when `level` equals DEPTH and `empty` exactly when `level` is 0.
- R2: A push while the queue is full (judged before any pop in the same cycle) is rejected and leaves the stored entries unchanged, and `ovf_err` goes high on the next cycle and stays high until reset.
- R3: `arrive_irq` is high for exactly the one cycle after each accepted push and low otherwise.
- R4: A popped entry returns the stored fields unchanged: the type bit (0 = read, 1 = write), the start sector and the sector count.
- R5: When no read can bypass, entries leave in arrival order.
- R6: The pop port presents the oldest stored read that has no older stored write overlapping it, even when older writes are present.
- R7: Ranges (sa, na) and (sb, nb) overlap exactly when sa < sb + nb and sb < sa + na, computed without wrap; a read overlapping an older write is never presented before that write leaves.
- R8: When no read is eligible, the oldest entry is presented.
- R9: `pop_valid` is low while the queue is empty, and a pop request on an empty queue has no effect.
- R10: A push and a pop in the same cycle both take effect, and `level` is then unchanged.
- R11: After reset the queue is empty, `ovf_err` is low and `arrive_irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 1 | Push a new command this cycle |
| push_wr | input | 1 | Type of the pushed command: 0 read, 1 write |
| push_lba | input | LBA_W | Start sector of the pushed command |
| push_cnt | input | CNT_W | Sector count of the pushed command |
| pop_req | input | 1 | Remove the presented entry this cycle |
| pop_valid | output | 1 | An entry is presented |
| pop_wr | output | 1 | Type of the presented entry |
| pop_lba | output | LBA_W | Start sector of the presented entry |
| pop_cnt | output | CNT_W | Sector count of the presented entry |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |
| level | output | LVL_W | Number of stored entries |
| ovf_err | output | 1 | Sticky: a push arrived while full |
| arrive_irq | output | 1 | One-cycle pulse after each accepted push |

## Verification
The bench builds the block with DEPTH 8, 8-bit sector addresses and 4-bit counts. The shallow queue lets random traffic reach full and empty states often, so rejected pushes, simultaneous push and pop at the limit, and the sticky error all occur many times. The narrow address space with short counts makes read-write overlaps and exactly adjacent ranges frequent, so blocked reads, unblocked reads and bypass past several writes are all exercised against a bench model that rescans every older write on each cycle.

// File: rtl/hq_pkg.sv
package hq_pkg;

  // Command type encoding carried in the type bit.
  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } cmd_kind_e;

  localparam int ADDR_MAX = 64;

  // Half-open sector span test, evaluated one bit wider so that it never wraps.
  function automatic logic spans_touch(
    input logic [ADDR_MAX-1:0] a_lo,
    input logic [ADDR_MAX-1:0] a_len,
    input logic [ADDR_MAX-1:0] b_lo,
    input logic [ADDR_MAX-1:0] b_len
  );
    logic [ADDR_MAX:0] a_end;
    logic [ADDR_MAX:0] b_end;
    a_end = {1'b0, a_lo} + {1'b0, a_len};
    b_end = {1'b0, b_lo} + {1'b0, b_len};
    return ({1'b0, a_lo} < b_end) && ({1'b0, b_lo} < a_end);
  endfunction

endpackage

// File: rtl/hq_overlap_vec.sv
module hq_overlap_vec #(
  parameter int DEPTH = 128,
  parameter int LBA_W = 32,
  parameter int CNT_W = 16
) (
  input  logic [LBA_W-1:0]             key_lba,
  input  logic [CNT_W-1:0]             key_cnt,
  input  logic [DEPTH-1:0][LBA_W-1:0]  ent_lba,
  input  logic [DEPTH-1:0][CNT_W-1:0]  ent_cnt,
  output logic [DEPTH-1:0]             hit
);
  import hq_pkg::*;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = spans_touch(ADDR_MAX'(key_lba), ADDR_MAX'(key_cnt),
                                ADDR_MAX'(ent_lba[g]), ADDR_MAX'(ent_cnt[g]));
  end

endmodule

// File: rtl/hq_select.sv
module hq_select #(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // Lowest set bit wins: slot 0 is the oldest entry.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/hostq_rdbypass.sv
module hostq_rdbypass #(
  parameter int DEPTH = 128,
  parameter int LBA_W = 32,
  parameter int CNT_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             push_wr,
  input  logic [LBA_W-1:0] push_lba,
  input  logic [CNT_W-1:0] push_cnt,
  input  logic             pop_req,
  output logic             pop_valid,
  output logic             pop_wr,
  output logic [LBA_W-1:0] pop_lba,
  output logic [CNT_W-1:0] pop_cnt,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level,
  output logic             ovf_err,
  output logic             arrive_irq
);
  import hq_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  // Age-ordered storage: slot 0 is the oldest entry.
  logic [DEPTH-1:0]             q_wr;
  logic [DEPTH-1:0][LBA_W-1:0]  q_lba;
  logic [DEPTH-1:0][CNT_W-1:0]  q_cnt;
  logic [DEPTH-1:0][LVL_W-1:0]  q_blk;   // older overlapping writes per read
  logic [LVL_W-1:0]             lvl_q;

  logic [DEPTH-1:0]             n_wr;
  logic [DEPTH-1:0][LBA_W-1:0]  n_lba;
  logic [DEPTH-1:0][CNT_W-1:0]  n_cnt;
  logic [DEPTH-1:0][LVL_W-1:0]  n_blk;

  // Named internal events, used by the checker.
  logic             do_push;
  logic             do_pop;
  logic             bypass_hit;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_is_wr;
  logic [LVL_W-1:0] wr_slot;
  logic [LVL_W-1:0] push_blk_n;

  logic [DEPTH-1:0] live;
  logic [DEPTH-1:0] eligible;
  logic [DEPTH-1:0] pop_drop;
  logic [DEPTH-1:0] push_hit;
  logic [DEPTH-1:0] pop_hit;
  logic             rd_found;
  logic [IDX_W-1:0] rd_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flags
    assign live[g]     = LVL_W'(g) < lvl_q;
    assign eligible[g] = live[g] && (q_wr[g] == CMD_READ) && (q_blk[g] == '0);
    assign pop_drop[g] = do_pop && (IDX_W'(g) == sel_idx);
  end

  hq_select #(.DEPTH(DEPTH)) u_pick (
    .cand  (eligible),
    .found (rd_found),
    .idx   (rd_idx)
  );

  assign sel_idx    = rd_found ? rd_idx : '0;
  assign bypass_hit = rd_found && (rd_idx != '0);
  assign sel_is_wr  = q_wr[sel_idx];

  assign do_push = push_req && (lvl_q != LVL_W'(DEPTH));
  assign do_pop  = pop_req && (lvl_q != '0);
  assign wr_slot = lvl_q - LVL_W'(do_pop);

  // Range of the incoming command against every slot.
  hq_overlap_vec #(.DEPTH(DEPTH), .LBA_W(LBA_W), .CNT_W(CNT_W)) u_push_ov (
    .key_lba (push_lba),
    .key_cnt (push_cnt),
    .ent_lba (q_lba),
    .ent_cnt (q_cnt),
    .hit     (push_hit)
  );

  // Range of the leaving command against every slot.
  hq_overlap_vec #(.DEPTH(DEPTH), .LBA_W(LBA_W), .CNT_W(CNT_W)) u_pop_ov (
    .key_lba (q_lba[sel_idx]),
    .key_cnt (q_cnt[sel_idx]),
    .ent_lba (q_lba),
    .ent_cnt (q_cnt),
    .hit     (pop_hit)
  );

  // A new read waits on every queued write that stays and overlaps it.
  assign push_blk_n = (push_wr == CMD_WRITE) ? '0 :
                      LVL_W'($countones(push_hit & live & q_wr & ~pop_drop));

  // Per-slot next state: compaction on pop, append on push.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam int NXT = (g < DEPTH - 1) ? g + 1 : g;
    logic shift;
    logic dec;
    assign shift = do_pop && (IDX_W'(g) >= sel_idx);
    assign dec   = sel_is_wr && live[NXT] && (q_wr[NXT] == CMD_READ) && pop_hit[NXT];

    always_comb begin
      n_wr[g]  = q_wr[g];
      n_lba[g] = q_lba[g];
      n_cnt[g] = q_cnt[g];
      n_blk[g] = q_blk[g];
      if (shift) begin
        if (g < DEPTH - 1) begin
          n_wr[g]  = q_wr[NXT];
          n_lba[g] = q_lba[NXT];
          n_cnt[g] = q_cnt[NXT];
          n_blk[g] = q_blk[NXT] - LVL_W'(dec);
        end else begin
          n_wr[g]  = 1'b0;
          n_lba[g] = '0;
          n_cnt[g] = '0;
          n_blk[g] = '0;
        end
      end
      if (do_push && (LVL_W'(g) == wr_slot)) begin
        n_wr[g]  = push_wr;
        n_lba[g] = push_lba;
        n_cnt[g] = push_cnt;
        n_blk[g] = push_blk_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_wr[g]  <= 1'b0;
        q_lba[g] <= '0;
        q_cnt[g] <= '0;
        q_blk[g] <= '0;
      end else begin
        q_wr[g]  <= n_wr[g];
        q_lba[g] <= n_lba[g];
        q_cnt[g] <= n_cnt[g];
        q_blk[g] <= n_blk[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= '0;
      ovf_err    <= 1'b0;
      arrive_irq <= 1'b0;
    end else begin
      lvl_q      <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
      ovf_err    <= ovf_err || (push_req && (lvl_q == LVL_W'(DEPTH)));
      arrive_irq <= do_push;
    end
  end

  assign pop_valid = (lvl_q != '0);
  assign pop_wr    = q_wr[sel_idx];
  assign pop_lba   = q_lba[sel_idx];
  assign pop_cnt   = q_cnt[sel_idx];
  assign full      = (lvl_q == LVL_W'(DEPTH));
  assign empty     = (lvl_q == '0);
  assign level     = lvl_q;

endmodule

// File: rtl/hq_chk.sv
module hq_chk #(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_req,
  input logic             pop_req,
  input logic             do_push,
  input logic             do_pop,
  input logic             bypass_hit,
  input logic             pop_wr,
  input logic             full,
  input logic             empty,
  input logic [LVL_W-1:0] level,
  input logic             ovf_err,
  input logic             arrive_irq
);

  assert_level_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_full_rejects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> (ovf_err && (level == $past(level))));

  assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> arrive_irq);

  assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !do_push |=> !arrive_irq);

  assert_bypass_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_hit |-> !pop_wr);

  assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> empty);

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && do_pop) |=> (level == $past(level)));

endmodule

bind hostq_rdbypass hq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .do_push    (do_push),
  .do_pop     (do_pop),
  .bypass_hit (bypass_hit),
  .pop_wr     (pop_wr),
  .full       (full),
  .empty      (empty),
  .level      (level),
  .ovf_err    (ovf_err),
  .arrive_irq (arrive_irq)
);

// File: tb/sim_hostq_rdbypass.sv
module sim_hostq_rdbypass;
  localparam int D  = 8;
  localparam int LW = 8;
  localparam int CW = 4;
  localparam int VW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0, push_wr = 1'b0, pop_req = 1'b0;
  logic [LW-1:0] push_lba = '0;
  logic [CW-1:0] push_cnt = '0;
  logic          pop_valid, pop_wr, full, empty, ovf_err, arrive_irq;
  logic [LW-1:0] pop_lba;
  logic [CW-1:0] pop_cnt;
  logic [VW-1:0] level;

  always #2 clk = ~clk;

  hostq_rdbypass #(.DEPTH(D), .LBA_W(LW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_wr(push_wr),
    .push_lba(push_lba), .push_cnt(push_cnt), .pop_req(pop_req),
    .pop_valid(pop_valid), .pop_wr(pop_wr), .pop_lba(pop_lba), .pop_cnt(pop_cnt),
    .full(full), .empty(empty), .level(level), .ovf_err(ovf_err), .arrive_irq(arrive_irq)
  );

  int checks = 0;
  int errors = 0;

  // Reference model, oldest entry at index 0.
  bit m_wr[D];
  int m_lba[D];
  int m_cnt[D];
  int m_n = 0;
  bit m_err = 0;
  bit m_irq = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Disjoint when one span ends at or before the other begins.
  function automatic bit spans_meet(int a0, int an, int b0, int bn);
    return !((a0 + an <= b0) || (b0 + bn <= a0));
  endfunction

  function automatic int want_sel();
    for (int i = 0; i < m_n; i++) begin
      if (!m_wr[i]) begin
        bit clear = 1;
        for (int j = 0; j < i; j++)
          if (m_wr[j] && spans_meet(m_lba[i], m_cnt[i], m_lba[j], m_cnt[j])) clear = 0;
        if (clear) return i;
      end
    end
    return 0;
  endfunction

  task automatic check_outputs();
    chk(int'(level) == m_n, "R1 level", int'(level), m_n);
    chk(full == (m_n == D), "R1 full", full, (m_n == D));
    chk(empty == (m_n == 0), "R1 empty", empty, (m_n == 0));
    chk(ovf_err == m_err, "R2 ovf_err", ovf_err, m_err);
    chk(arrive_irq == m_irq, "R3 arrive_irq", arrive_irq, m_irq);
    chk(pop_valid == (m_n > 0), "R9 pop_valid", pop_valid, (m_n > 0));
    if (m_n > 0) begin
      int s = want_sel();
      string tg;
      bit have_rd = 0;
      for (int i = 0; i < m_n; i++) if (!m_wr[i]) have_rd = 1;
      tg = (s > 0) ? "R6 bypass" : (m_wr[0] ? (have_rd ? "R7 blocked" : "R5 order") : "R8 oldest");
      chk(pop_wr == m_wr[s], {tg, " type"}, pop_wr, m_wr[s]);
      chk(int'(pop_lba) == m_lba[s], {"R4 ", tg, " lba"}, int'(pop_lba), m_lba[s]);
      chk(int'(pop_cnt) == m_cnt[s], {"R4 ", tg, " cnt"}, int'(pop_cnt), m_cnt[s]);
    end
  endtask

  // Checks the current cycle, drives one cycle of stimulus, advances the model.
  task automatic step(input bit pu, input bit w, input int lba, input int cnt, input bit po);
    int n0;
    bit acc;
    check_outputs();
    push_req = pu; push_wr = w; push_lba = LW'(lba); push_cnt = CW'(cnt); pop_req = po;
    n0  = m_n;
    acc = pu && (n0 < D);
    if (po && n0 > 0) begin
      int s = want_sel();
      for (int k = s; k < m_n - 1; k++) begin
        m_wr[k] = m_wr[k+1]; m_lba[k] = m_lba[k+1]; m_cnt[k] = m_cnt[k+1];
      end
      m_n--;
    end
    if (acc) begin
      m_wr[m_n] = w; m_lba[m_n] = lba; m_cnt[m_n] = cnt; m_n++;
    end
    if (pu && n0 == D) m_err = 1;
    m_irq = acc;
    @(posedge clk);
    @(negedge clk);
    push_req = 0; pop_req = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(empty && !ovf_err && !arrive_irq && level == '0, "R11 reset", int'(level), 0);
    idle();

    // R6/R7/R8: write 10..13, read 12..13 blocked, read 20 free
    step(1, 1, 10, 4, 0);
    step(1, 0, 12, 2, 0);
    step(1, 0, 20, 1, 0);
    chk(int'(pop_lba) == 20 && !pop_wr, "R6 free read first", int'(pop_lba), 20);
    step(0, 0, 0, 0, 1);
    chk(int'(pop_lba) == 10 && pop_wr, "R8 write before blocked read", int'(pop_lba), 10);
    step(0, 0, 0, 0, 1);
    chk(int'(pop_lba) == 12 && !pop_wr, "R7 read after its write", int'(pop_lba), 12);
    step(0, 0, 0, 0, 1);

    // R7: adjacent spans and a zero-count write do not block
    step(1, 1, 30, 4, 0);
    step(1, 0, 34, 2, 0);
    chk(int'(pop_lba) == 34, "R7 adjacent not overlapping", int'(pop_lba), 34);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(1, 1, 5, 0, 0);
    step(1, 0, 5, 1, 0);
    chk(int'(pop_lba) == 5 && !pop_wr, "R7 zero count write", int'(pop_lba), 5);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);

    // R9: pop on empty
    step(0, 0, 0, 0, 1);
    chk(empty, "R9 pop on empty", int'(level), 0);

    // R5/R2/R10: fill with writes, overflow, push+pop at full
    for (int i = 0; i < D; i++) step(1, 1, 40 + i, 1, 0);
    chk(full, "R1 full after D pushes", int'(level), D);
    step(1, 0, 99, 1, 0);
    step(1, 0, 98, 1, 1);
    chk(int'(level) == D - 1 && ovf_err, "R10 push rejected at full with pop", int'(level), D - 1);
    for (int i = 0; i < D; i++) step(0, 0, 0, 0, 1);
    step(1, 0, 7, 2, 1);
    step(1, 1, 8, 2, 1);
    chk(int'(level) == 1, "R10 push and pop together", int'(level), 1);

    // Random traffic in phases biased toward filling and draining
    for (int c = 0; c < 4000; c++) begin
      int pp = ((c / 250) % 2 == 0) ? 65 : 35;
      bit pu = ($urandom % 100) < pp;
      bit po = ($urandom % 100) < (100 - pp);
      step(pu, bit'($urandom % 2), int'($urandom % 32), int'($urandom % 6), po);
    end
    idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule